// File: doc/BRIEF.md
# Program-ROM Bank Mapper with Register-Select Remap

This block sits on the cartridge side of an 8-bit CPU bus. It watches CPU write cycles in a 32 KB window (offset 0x0000-0x7FFF) and holds the program banking state: two program bank registers, a slot-swap mode bit and a two-bit nametable mirroring code. For each CPU read address in the same window it produces a program-ROM address. The window is split into four 8 KB slots, and each slot is backed by one bank of the ROM.

Board variants wire the CPU's low address lines to the chip's two register-select inputs in different ways. A static parameter picks one of three wirings, and the selected remap is applied before register decode. A second static parameter picks the chip type. The wide type has 5-bit bank registers and a mode bit. The narrow type has 4-bit bank registers, no mode bit, and a second alias of the mirroring register.

The ROM size is a power-of-two number of 8 KB banks. Every bank number is masked to that size. The two fixed slots always point at the last bank and the second-to-last bank, whatever the ROM size.

Top module: `prg_bank_mapper`

## Requirements
- R1: After reset, bank register 0 holds 0 and bank register 1 holds 1. The mode bit is clear and `mirror` is 0 (vertical).
- R2: With VARIANT=1, the group is taken from window address bits 14:12 and the register select from address bits 3:2. Address bits 11:4 and 1:0 are ignored.
- R3: With VARIANT=2, the group is taken from bits 14:12 and the register select is {bit 0, bit 1}, so address bits 0 and 1 are swapped. Bits 11:2 are ignored.
- R4: With VARIANT=0, the register select is address bits 1:0. A write whose bits 11:2 are not all zero matches no register.
- R5: A matching write to group 0 (offset 0x0000-0x0FFF with the select in 0..3) loads bank register 0. A matching write to group 2 loads bank register 1. The loaded value is the data masked to 5 bits when WIDE=1 and to 4 bits when WIDE=0.
- R6: With the mode bit clear, slots 0, 1, 2 and 3 map to bank register 0, bank register 1, bank N-2 and bank N-1, where N is ROM_BANKS.
- R7: When WIDE=1, a write to group 1 with select 2 or 3 sets the mode bit to data bit 1. With the mode bit set, slots 0, 1, 2 and 3 map to bank N-2, bank register 1, bank register 0 and bank N-1.
- R8: A write to group 1 with select 0 or 1 sets `mirror` to data bits 1:0. The codes are 0 vertical, 1 horizontal, 2 single-screen A and 3 single-screen B. When WIDE=0, selects 2 and 3 also write `mirror`, and the mode bit stays clear.
- R9: The slot is `rd_addr[14:13]`. `rom_addr` is {selected bank AND (N-1), `rd_addr[12:0]`}.
- R10: A write to groups 3 to 7, or a write that R4 rejects, changes neither bank register, the mode bit nor `mirror`.
- R11: A write captured at a rising clock edge shows on `mirror` and `rom_addr` from that edge on. `rom_addr` follows `rd_addr` within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 15 | Write offset inside the 32 KB window |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 15 | Read offset inside the 32 KB window |
| rom_addr | output | $clog2(ROM_BANKS)+13 | Translated program-ROM byte address |
| mirror | output | 2 | Nametable mirroring code |

## Verification
Register state changes at the rising edge that samples `wr_en`. `mirror` therefore shows a write one edge after it was driven, and `rom_addr` shows it at the same edge. `rom_addr` also responds to `rd_addr` with no register delay, so a read-address change is visible in the same cycle. The bench drives inputs shortly after each rising edge and lets its behavioural model update on the same edges. It compares both outputs of three differently configured instances at every falling edge. A result that arrives one cycle early or late therefore shows up as a mismatch in the cycle where it first goes wrong.

// File: rtl/prg_bank_mapper_pkg.sv
package prg_bank_mapper_pkg;

   // window and slot geometry
   localparam int WIN_AW     = 15;
   localparam int SLOT_OFS_W = 13;
   localparam int GROUP_W    = 3;
   localparam int SEL_W      = 2;
   localparam int BANK_REG_W = 5;

   // register-select wiring variants
   localparam int REMAP_PASS = 0;
   localparam int REMAP_HIGH = 1;
   localparam int REMAP_SWAP = 2;

   typedef enum logic [1:0] {
      MIR_VERT  = 2'd0,
      MIR_HORZ  = 2'd1,
      MIR_ONE_A = 2'd2,
      MIR_ONE_B = 2'd3
   } mirror_e;

   typedef struct packed {
      logic               hit;
      logic [GROUP_W-1:0] group;
      logic [SEL_W-1:0]   sel;
   } reg_sel_t;

endpackage

// File: rtl/prg_addr_remap.sv
module prg_addr_remap
   import prg_bank_mapper_pkg::*;
#(
   parameter int VARIANT = REMAP_HIGH
) (
   input  logic [WIN_AW-1:0] addr,
   output reg_sel_t          sel_o
);

   localparam int GROUP_LSB = WIN_AW - GROUP_W;

   assign sel_o.group = addr[WIN_AW-1:GROUP_LSB];

   generate
      if (VARIANT == REMAP_PASS) begin : g_pass
         // only the exact register offsets decode
         assign sel_o.sel = addr[1:0];
         assign sel_o.hit = (addr[GROUP_LSB-1:2] == '0);
      end else if (VARIANT == REMAP_HIGH) begin : g_high
         logic unused_low;
         assign unused_low = ^{addr[GROUP_LSB-1:4], addr[1:0]};
         assign sel_o.sel  = addr[3:2];
         assign sel_o.hit  = 1'b1;
      end else begin : g_swap
         logic unused_mid;
         assign unused_mid = ^addr[GROUP_LSB-1:2];
         assign sel_o.sel  = {addr[0], addr[1]};
         assign sel_o.hit  = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/prg_reg_decode.sv
module prg_reg_decode
   import prg_bank_mapper_pkg::*;
#(
   parameter bit WIDE = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  reg_sel_t              sel_i,
   input  logic [7:0]            wr_data,
   output logic [BANK_REG_W-1:0] bank0_o,
   output logic [BANK_REG_W-1:0] bank1_o,
   output logic                  swap_o,
   output mirror_e               mirror_o
);

   localparam int REG_W = WIDE ? BANK_REG_W : BANK_REG_W - 1;
   localparam logic [BANK_REG_W-1:0] DATA_MASK = BANK_REG_W'((1 << REG_W) - 1);
   localparam logic [GROUP_W-1:0] GRP_BANK0 = GROUP_W'(0);
   localparam logic [GROUP_W-1:0] GRP_CTRL  = GROUP_W'(1);
   localparam logic [GROUP_W-1:0] GRP_BANK1 = GROUP_W'(2);

   logic                  wr_hit;
   logic                  ld_bank0;
   logic                  ld_bank1;
   logic                  ld_mirror;
   logic                  ld_mode;
   logic [BANK_REG_W-1:0] bank_val;
   logic [BANK_REG_W-1:0] bank0_q;
   logic [BANK_REG_W-1:0] bank1_q;
   mirror_e               mirror_q;
   logic                  unused_bits;

   assign unused_bits = ^{wr_data[7:BANK_REG_W], sel_i.sel[0]};

   always_comb begin
      wr_hit    = wr_en && sel_i.hit;
      ld_bank0  = wr_hit && (sel_i.group == GRP_BANK0);
      ld_bank1  = wr_hit && (sel_i.group == GRP_BANK1);
      ld_mirror = wr_hit && (sel_i.group == GRP_CTRL) && (!sel_i.sel[1] || !WIDE);
      ld_mode   = wr_hit && (sel_i.group == GRP_CTRL) && sel_i.sel[1] && WIDE;
      bank_val  = wr_data[BANK_REG_W-1:0] & DATA_MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank0_q  <= '0;
         bank1_q  <= BANK_REG_W'(1);
         mirror_q <= MIR_VERT;
      end else begin
         if (ld_bank0) begin
            bank0_q <= bank_val;
         end
         if (ld_bank1) begin
            bank1_q <= bank_val;
         end
         if (ld_mirror) begin
            mirror_q <= mirror_e'(wr_data[1:0]);
         end
      end
   end

   generate
      if (WIDE) begin : g_mode
         logic swap_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               swap_q <= 1'b0;
            end else if (ld_mode) begin
               swap_q <= wr_data[1];
            end
         end
         assign swap_o = swap_q;
      end else begin : g_no_mode
         logic unused_mode;
         assign unused_mode = ld_mode;
         assign swap_o      = 1'b0;
      end
   endgenerate

   assign bank0_o  = bank0_q;
   assign bank1_o  = bank1_q;
   assign mirror_o = mirror_q;

endmodule

// File: rtl/prg_slot_map.sv
module prg_slot_map
   import prg_bank_mapper_pkg::*;
#(
   parameter int ROM_BANKS = 16,
   localparam int BW       = $clog2(ROM_BANKS),
   localparam int ROM_AW   = BW + SLOT_OFS_W
) (
   input  logic [BANK_REG_W-1:0] bank0_i,
   input  logic [BANK_REG_W-1:0] bank1_i,
   input  logic                  swap_i,
   input  logic [WIN_AW-1:0]     rd_addr,
   output logic [ROM_AW-1:0]     rom_addr
);

   localparam logic [BW-1:0] LAST_BANK = BW'(ROM_BANKS - 1);
   localparam logic [BW-1:0] PREV_BANK = BW'(ROM_BANKS - 2);

   logic [BW-1:0] reg0_m;
   logic [BW-1:0] reg1_m;
   logic [BW-1:0] slot_bank;

   // fit the stored register width to the ROM bank index width
   generate
      if (BW < BANK_REG_W) begin : g_trunc
         logic unused_hi;
         assign unused_hi = ^{bank0_i[BANK_REG_W-1:BW], bank1_i[BANK_REG_W-1:BW]};
         assign reg0_m    = bank0_i[BW-1:0];
         assign reg1_m    = bank1_i[BW-1:0];
      end else if (BW == BANK_REG_W) begin : g_same
         assign reg0_m = bank0_i;
         assign reg1_m = bank1_i;
      end else begin : g_extend
         assign reg0_m = {{(BW-BANK_REG_W){1'b0}}, bank0_i};
         assign reg1_m = {{(BW-BANK_REG_W){1'b0}}, bank1_i};
      end
   endgenerate

   always_comb begin
      unique case (rd_addr[WIN_AW-1:SLOT_OFS_W])
         2'd0:    slot_bank = swap_i ? PREV_BANK : reg0_m;
         2'd1:    slot_bank = reg1_m;
         2'd2:    slot_bank = swap_i ? reg0_m : PREV_BANK;
         default: slot_bank = LAST_BANK;
      endcase
   end

   assign rom_addr = {slot_bank, rd_addr[SLOT_OFS_W-1:0]};

endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
   import prg_bank_mapper_pkg::*;
#(
   parameter int  VARIANT   = REMAP_HIGH,
   parameter bit  WIDE      = 1'b1,
   parameter int  ROM_BANKS = 16,
   localparam int BW        = $clog2(ROM_BANKS),
   localparam int ROM_AW    = BW + SLOT_OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [14:0]       wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [14:0]       rd_addr,
   output logic [ROM_AW-1:0] rom_addr,
   output logic [1:0]        mirror
);

   initial begin
      assert (VARIANT >= REMAP_PASS && VARIANT <= REMAP_SWAP)
         else $error("prg_bank_mapper: VARIANT out of range");
      assert (ROM_BANKS >= 2 && ROM_BANKS <= 256)
         else $error("prg_bank_mapper: ROM_BANKS out of range");
      assert ((ROM_BANKS & (ROM_BANKS - 1)) == 0)
         else $error("prg_bank_mapper: ROM_BANKS must be a power of two");
   end

   reg_sel_t              wr_sel;
   logic [BANK_REG_W-1:0] bank0_q;
   logic [BANK_REG_W-1:0] bank1_q;
   logic                  swap_q;
   mirror_e               mirror_q;

   prg_addr_remap #(
      .VARIANT (VARIANT)
   ) u_remap (
      .addr  (wr_addr),
      .sel_o (wr_sel)
   );

   prg_reg_decode #(
      .WIDE (WIDE)
   ) u_decode (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .sel_i    (wr_sel),
      .wr_data  (wr_data),
      .bank0_o  (bank0_q),
      .bank1_o  (bank1_q),
      .swap_o   (swap_q),
      .mirror_o (mirror_q)
   );

   prg_slot_map #(
      .ROM_BANKS (ROM_BANKS)
   ) u_slots (
      .bank0_i  (bank0_q),
      .bank1_i  (bank1_q),
      .swap_i   (swap_q),
      .rd_addr  (rd_addr),
      .rom_addr (rom_addr)
   );

   assign mirror = mirror_q;

endmodule

// File: rtl/prg_bank_mapper_chk.sv
module prg_bank_mapper_chk #(
   parameter int  VARIANT   = 1,
   parameter bit  WIDE      = 1'b1,
   parameter int  ROM_BANKS = 16,
   localparam int BW        = $clog2(ROM_BANKS),
   localparam int ROM_AW    = BW + 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [14:0]       wr_addr,
   input logic [7:0]        wr_data,
   input logic [14:0]       rd_addr,
   input logic [ROM_AW-1:0] rom_addr,
   input logic [1:0]        mirror,
   input logic [4:0]        bank0,
   input logic [4:0]        bank1,
   input logic              swap
);

   localparam logic [4:0]    LOAD_MASK = WIDE ? 5'h1F : 5'h0F;
   localparam logic [BW-1:0] LAST_IDX  = BW'(ROM_BANKS - 1);
   localparam logic [BW-1:0] PREV_IDX  = BW'(ROM_BANKS - 2);

   logic exact_ok;
   logic unused_chk;

   assign exact_ok   = (VARIANT != 0) || (wr_addr[11:2] == 10'd0);
   assign unused_chk = ^{wr_addr[1:0], wr_data[7:5]};

   assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (mirror == 2'd0 && bank0 == 5'd0 && bank1 == 5'd1 && !swap));

   assert_bank0_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && exact_ok && wr_addr[14:12] == 3'd0)
      |=> (bank0 == ($past(wr_data[4:0]) & LOAD_MASK)));

   assert_bank1_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && exact_ok && wr_addr[14:12] == 3'd2)
      |=> (bank1 == ($past(wr_data[4:0]) & LOAD_MASK)));

   assert_no_effect_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr[14:12] >= 3'd3 || !exact_ok))
      |=> ($stable(bank0) && $stable(bank1) && $stable(swap) && $stable(mirror)));

   assert_offset_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rom_addr[12:0] == rd_addr[12:0]);

   assert_last_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr[14:13] == 2'd3) |-> (rom_addr[ROM_AW-1:13] == LAST_IDX));

   assert_swapped_slot0_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (swap && rd_addr[14:13] == 2'd0) |-> (rom_addr[ROM_AW-1:13] == PREV_IDX));

   assert_narrow_no_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!WIDE && wr_en && exact_ok && wr_addr[14:12] == 3'd1)
      |=> (!swap && mirror == $past(wr_data[1:0])));

endmodule

bind prg_bank_mapper prg_bank_mapper_chk #(
   .VARIANT   (VARIANT),
   .WIDE      (WIDE),
   .ROM_BANKS (ROM_BANKS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .wr_data  (wr_data),
   .rd_addr  (rd_addr),
   .rom_addr (rom_addr),
   .mirror   (mirror),
   .bank0    (bank0_q),
   .bank1    (bank1_q),
   .swap     (swap_q)
);

// File: tb/prg_bank_mapper_bench.sv
module prg_bank_mapper_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [14:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [14:0] rd_addr = '0;
   logic [16:0] rom_a;
   logic [16:0] rom_b;
   logic [17:0] rom_c;
   logic [1:0]  mir_a;
   logic [1:0]  mir_b;
   logic [1:0]  mir_c;

   int    total = 0;
   int    bad = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   // per-instance configuration: a = high-select wide 16 banks,
   // b = swapped-select narrow 16 banks, c = pass-through wide 32 banks
   int cfg_var[3]   = '{1, 2, 0};
   int cfg_wide[3]  = '{1, 0, 1};
   int cfg_banks[3] = '{16, 16, 32};

   int m_b0[3];
   int m_b1[3];
   int m_swap[3];
   int m_mir[3];

   always #4 clk = ~clk;

   prg_bank_mapper #(.VARIANT(1), .WIDE(1'b1), .ROM_BANKS(16)) u_prg_bank_mapper (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rom_addr(rom_a), .mirror(mir_a));

   prg_bank_mapper #(.VARIANT(2), .WIDE(1'b0), .ROM_BANKS(16)) u_prg_bank_mapper_b (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rom_addr(rom_b), .mirror(mir_b));

   prg_bank_mapper #(.VARIANT(0), .WIDE(1'b1), .ROM_BANKS(32)) u_prg_bank_mapper_c (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rom_addr(rom_c), .mirror(mir_c));

   task automatic model_write(input int k, input int a, input int d);
      int grp;
      int sel;
      bit hit;
      grp = (a / 4096) % 8;
      case (cfg_var[k])
         1: begin sel = (a / 4) % 4; hit = 1'b1; end
         2: begin sel = (a % 2) * 2 + (a / 2) % 2; hit = 1'b1; end
         default: begin sel = a % 4; hit = ((a / 4) % 1024) == 0; end
      endcase
      if (hit) begin
         if (grp == 0) m_b0[k] = d % (cfg_wide[k] != 0 ? 32 : 16);
         else if (grp == 2) m_b1[k] = d % (cfg_wide[k] != 0 ? 32 : 16);
         else if (grp == 1) begin
            if (sel < 2 || cfg_wide[k] == 0) m_mir[k] = d % 4;
            else m_swap[k] = (d / 2) % 2;
         end
      end
   endtask

   function automatic int expect_rom(input int k, input int rd);
      int slot;
      int bank;
      int n;
      n = cfg_banks[k];
      slot = (rd / 8192) % 4;
      if (m_swap[k] != 0) begin
         case (slot)
            0: bank = n - 2;
            1: bank = m_b1[k];
            2: bank = m_b0[k];
            default: bank = n - 1;
         endcase
      end else begin
         case (slot)
            0: bank = m_b0[k];
            1: bank = m_b1[k];
            2: bank = n - 2;
            default: bank = n - 1;
         endcase
      end
      return (bank % n) * 8192 + rd % 8192;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < 3; k++) begin
            m_b0[k] = 0; m_b1[k] = 1; m_swap[k] = 0; m_mir[k] = 0;
         end
      end else if (wr_en) begin
         for (int k = 0; k < 3; k++) model_write(k, int'(wr_addr), int'(wr_data));
      end
   end

   task automatic check(input int k, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s inst=%0d %s actual=%h expected=%h", cur_req, k, what, act, exp);
      end
   endtask

   // compare every cycle, away from the active edge (R11 timing)
   always @(negedge clk) begin
      if (!done) begin
         check(0, "rom_addr", int'(rom_a), expect_rom(0, int'(rd_addr)));
         check(1, "rom_addr", int'(rom_b), expect_rom(1, int'(rd_addr)));
         check(2, "rom_addr", int'(rom_c), expect_rom(2, int'(rd_addr)));
         check(0, "mirror", int'(mir_a), m_mir[0]);
         check(1, "mirror", int'(mir_b), m_mir[1]);
         check(2, "mirror", int'(mir_c), m_mir[2]);
      end
   end

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic wr(input int a, input int d);
      wr_en = 1'b1;
      wr_addr = 15'(a);
      wr_data = 8'(d);
      step();
      wr_en = 1'b0;
   endtask

   task automatic sweep(input int ofs);
      for (int s = 0; s < 4; s++) begin
         rd_addr = 15'(s * 8192 + ofs);
         step();
      end
   endtask

   initial begin
      #10000000;
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog %s expired", cur_req);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1: reset values during and right after reset
      cur_req = "R1";
      step();
      sweep(13'h0123);
      rst_n = 1'b1;
      step();
      sweep(13'h1FFF);

      // R9: slot selection and offset pass-through with reset banks
      cur_req = "R9";
      sweep(13'h0000);
      sweep(13'h0ABC);

      // R5: bank register loads with masking per chip type
      cur_req = "R5";
      wr(16'h0000, 8'h3A);
      sweep(13'h0044);
      wr(16'h2003, 8'h17);
      sweep(13'h1010);
      wr(16'h0002, 8'hFF);
      wr(16'h2001, 8'h05);

      // R6: mode clear slot layout
      cur_req = "R6";
      sweep(13'h0707);

      // R7: mode bit on wide chips; R2 R3 R4 select wiring differences
      cur_req = "R7 R2 R3 R4";
      wr(16'h1008, 8'h02);
      sweep(13'h0001);
      wr(16'h1002, 8'h02);
      sweep(13'h0002);
      wr(16'h100C, 8'h00);
      sweep(13'h0003);

      // R8: mirroring register and narrow-chip alias
      cur_req = "R8";
      wr(16'h1000, 8'h01);
      step();
      wr(16'h1001, 8'hFF);
      step();
      wr(16'h1003, 8'h0E);
      sweep(13'h0100);
      wr(16'h1004, 8'h01);
      sweep(13'h0200);

      // R10: unmatched groups and rejected pass-through offsets
      cur_req = "R10";
      for (int g = 3; g < 8; g++) begin
         wr(g * 4096 + g, 8'hFF - g);
      end
      wr(16'h0010, 8'h09);
      wr(16'h2020, 8'h0C);
      sweep(13'h0F0F);

      // R11: back-to-back writes, each visible from its own edge
      cur_req = "R11";
      wr(16'h0000, 8'h04);
      wr(16'h0000, 8'h06);
      wr(16'h2000, 8'h07);
      sweep(13'h0055);

      // R2 R3 R4 R10: mixed random traffic
      cur_req = "R2 R3 R4 R10";
      for (int i = 0; i < 600; i++) begin
         wr_en = 1'($urandom_range(0, 1));
         wr_addr = 15'($urandom_range(0, 7) * 4096 + $urandom_range(0, 15));
         wr_data = 8'($urandom_range(0, 255));
         rd_addr = 15'($urandom_range(0, 32767));
         step();
      end
      wr_en = 1'b0;
      sweep(13'h1234);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule